// File: doc/BRIEF.md
# Intra-Wave Collision Layer Sequencer

A wave of fragment work can hold invocations that overlap one another at the same pixel. The wave carries a per-quad collision word, in which each bit stands for a group of four lanes. A set bit marks a quad that opens a new overlap layer. Such a layer may only run its ordered code after every lane below that quad has run. This block takes that word and releases the wave's lanes one layer at a time, from the lowest lanes upward. The layers can then run back to back inside one wave.

A client pulses `start` with the collision word, the wave width and the wave's active-lane mask. One cycle later the first layer's lane mask is shown with `valid`. Each `step` pulse moves to the next layer on the following cycle. `last` marks the final layer, and stepping past it returns the block to idle. The lane mask is always limited to the lanes that were active at start. A layer that ends up with no lanes is still presented, and `empty` is raised with it.

Top module: `quad_layer_seq`

## Requirements
- R1: After reset `valid`, `last` and `empty` are low and `lane_en` is all zero.
- R2: In 32-lane mode (`wide`=0) only bits 7:0 of `coll_word` count. In 64-lane mode (`wide`=1) only bits 15:0 count. Higher bits have no effect on any layer, and lanes 63:32 stay zero in 32-lane mode.
- R3: Bit q of the word stands for lanes 4q..4q+3. The first layer starts at lane 0. A layer that starts at quad s covers quads s up to, but not including, the lowest set bit above s.
- R4: A word with no counted bits set gives exactly one layer. That layer covers the whole wave (32 or 64 lanes) and `last` is high with it.
- R5: The final layer always extends to the top lane of the wave (lane 31 or lane 63).
- R6: `lane_en` equals the layer's lane range ANDed with `act_mask` as sampled at start. When that result is zero the layer is still shown with `valid` high and `empty` high. `empty` is low otherwise.
- R7: `last` is high only while the final layer is shown. A `step` while `last` is high makes `valid` and `last` low on the next cycle.
- R8: `start` has no effect while a sequence is in progress. `step` has no effect while the block is idle.
- R9: The first layer appears in the cycle after `start` is accepted. Each `step` shows the next layer in the cycle after the step. Without a step, the outputs hold.
- R10: Bit 0 of the word has no effect, because the first layer starts at quad 0 anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new wave when idle |
| wide | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| coll_word | input | 32 | Per-quad layer-start bits, low bits used |
| act_mask | input | 64 | Active lanes of the wave |
| step | input | 1 | Advance to the next layer |
| lane_en | output | 64 | Lanes enabled for the current layer |
| valid | output | 1 | A layer is being shown |
| last | output | 1 | The shown layer is the final one |
| empty | output | 1 | The shown layer has no enabled lanes |

## Verification
The sequencer is driven with several kinds of collision word, and each kind separates a different fault:

- The worked five-layer example in 64-lane mode checks the layer boundaries.
- An all-zero word checks the single-layer case.
- An all-ones word produces one quad per layer, which exposes off-by-one errors at layer ends.
- Bit-0-only words and words with junk in the high bits, in both widths, show whether the word is cut to the right width.
- Sparse active masks force empty layers, to confirm that they are still emitted and flagged.

Random words and masks under a fixed seed are then checked against a layer list computed in the bench. Stray `start` pulses during a sequence and stray `step` pulses while idle check that both are ignored.

// File: rtl/qls_pkg.sv
package qls_pkg;
  typedef enum logic {WAVE_NARROW = 1'b0, WAVE_WIDE = 1'b1} wave_e;

  typedef struct packed {
    logic vld;
    logic fin;
    logic none;
  } layer_flags_t;
endpackage

// File: rtl/qls_scan.sv
// Finds the lowest set quad bit strictly above the base quad.
module qls_scan #(
  parameter int NQ   = 16,
  parameter int IW   = 5
) (
  input  logic [NQ-1:0] qmask,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (qmask[i] && (IW'(i) > base)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/qls_expand.sv
// Turns a half-open quad range [lo, hi) into a lane mask.
module qls_expand #(
  parameter int LANES  = 64,
  parameter int QUAD_W = 4,
  parameter int IW     = 5
) (
  input  logic [IW-1:0]    lo,
  input  logic [IW-1:0]    hi,
  output logic [LANES-1:0] lanes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [IW-1:0] QIDX = IW'(l / QUAD_W);
    assign lanes[l] = (QIDX >= lo) && (QIDX < hi);
  end
endmodule

// File: rtl/quad_layer_seq.sv
module quad_layer_seq #(
  parameter int MAX_LANES    = 64,
  parameter int NARROW_LANES = 32,
  parameter int WORD_W       = 32,
  parameter int QUAD_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 wide,
  input  logic [WORD_W-1:0]    coll_word,
  input  logic [MAX_LANES-1:0] act_mask,
  input  logic                 step,
  output logic [MAX_LANES-1:0] lane_en,
  output logic                 valid,
  output logic                 last,
  output logic                 empty
);
  import qls_pkg::*;

  localparam int NQ   = MAX_LANES / QUAD_W;
  localparam int NQ_N = NARROW_LANES / QUAD_W;
  localparam int IW   = $clog2(NQ) + 1;

  // Wave state latched at start
  logic [NQ-1:0]        qmask_q;
  logic [MAX_LANES-1:0] act_q;
  wave_e                wide_q;
  logic [IW-1:0]        end_q;
  layer_flags_t         flags_q;
  logic [MAX_LANES-1:0] lane_q;

  logic accept, advance, finish;
  assign accept  = start && !flags_q.vld;
  assign advance = step && flags_q.vld && !flags_q.fin;
  assign finish  = step && flags_q.vld && flags_q.fin;

  // Source selection: fresh inputs on accept, stored state on advance
  logic [NQ-1:0]        cut_mask;
  logic [NQ-1:0]        src_mask;
  logic [MAX_LANES-1:0] src_act;
  wave_e                src_wide;
  logic [IW-1:0]        src_base;
  logic [IW-1:0]        src_top;

  for (genvar q = 0; q < NQ; q++) begin : g_cut
    if (q < NQ_N) begin : g_low
      assign cut_mask[q] = coll_word[q];
    end else begin : g_high
      assign cut_mask[q] = coll_word[q] && wide;
    end
  end

  always_comb begin
    if (accept) begin
      src_mask = cut_mask;
      src_act  = act_mask;
      src_wide = wave_e'(wide);
      src_base = '0;
    end else begin
      src_mask = qmask_q;
      src_act  = act_q;
      src_wide = wide_q;
      src_base = end_q;
    end
    src_top = (src_wide == WAVE_WIDE) ? IW'(NQ) : IW'(NQ_N);
  end

  logic          nxt_found;
  logic [IW-1:0] nxt_idx;
  logic [IW-1:0] end_c;

  qls_scan #(.NQ(NQ), .IW(IW)) u_scan (
    .qmask (src_mask),
    .base  (src_base),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  assign end_c = nxt_found ? nxt_idx : src_top;

  logic [MAX_LANES-1:0] range_c;
  logic [MAX_LANES-1:0] lanes_c;

  qls_expand #(.LANES(MAX_LANES), .QUAD_W(QUAD_W), .IW(IW)) u_expand (
    .lo    (src_base),
    .hi    (end_c),
    .lanes (range_c)
  );

  assign lanes_c = range_c & src_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      qmask_q <= '0;
      act_q   <= '0;
      wide_q  <= WAVE_NARROW;
      end_q   <= '0;
      flags_q <= '0;
      lane_q  <= '0;
    end else if (accept || advance) begin
      qmask_q      <= src_mask;
      act_q        <= src_act;
      wide_q       <= src_wide;
      end_q        <= end_c;
      lane_q       <= lanes_c;
      flags_q.vld  <= 1'b1;
      flags_q.fin  <= !nxt_found;
      flags_q.none <= (lanes_c == '0);
    end else if (finish) begin
      flags_q <= '0;
      lane_q  <= '0;
    end
  end

  assign lane_en = lane_q;
  assign valid   = flags_q.vld;
  assign last    = flags_q.fin;
  assign empty   = flags_q.none;
endmodule

// File: rtl/qls_checker.sv
module qls_checker #(
  parameter int MAX_LANES    = 64,
  parameter int NARROW_LANES = 32,
  parameter int IW           = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step,
  input logic                 valid,
  input logic                 last,
  input logic                 empty,
  input logic [MAX_LANES-1:0] lane_en,
  input logic [MAX_LANES-1:0] act_q,
  input logic                 wide_q,
  input logic [IW-1:0]        end_q
);
  // R9
  hold_layer_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !step) |=> (valid && $stable(lane_en) && $stable(last)));

  // R7
  drop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && last && step) |=> !valid);

  // R7
  idle_not_last_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (!last && !empty));

  // R6
  inside_active_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((lane_en & ~act_q) == '0));

  // R6
  empty_means_none_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && empty) |-> (lane_en == '0));

  // R2
  narrow_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !wide_q) |-> (lane_en[MAX_LANES-1:NARROW_LANES] == '0));

  // R3
  layer_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && step && !last) |=> (valid && (end_q > $past(end_q))));
endmodule

bind quad_layer_seq qls_checker #(
  .MAX_LANES(MAX_LANES), .NARROW_LANES(NARROW_LANES), .IW(IW)
) u_qls_chk (
  .clk(clk), .rst(rst), .step(step), .valid(valid), .last(last),
  .empty(empty), .lane_en(lane_en), .act_q(act_q), .wide_q(wide_q),
  .end_q(end_q)
);

// File: tb/test_quad_layer_seq.sv
`timescale 1ns/1ps
module test_quad_layer_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, wide, step;
  logic [31:0] coll_word;
  logic [63:0] act_mask;
  logic [63:0] lane_en;
  logic        valid, last, empty;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  quad_layer_seq i_quad_layer_seq (
    .clk(clk), .rst(rst), .start(start), .wide(wide), .coll_word(coll_word),
    .act_mask(act_mask), .step(step), .lane_en(lane_en), .valid(valid),
    .last(last), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one wave and walks all its layers against a bench-side model.
  // poke_start: pulse start during the first layer (R8).
  task automatic run_wave(input logic [31:0] w, input logic wd,
                          input logic [63:0] a, input bit poke_start);
    int n, s, e;
    logic [63:0] exp;
    start = 1'b1; coll_word = w; wide = wd; act_mask = a;
    @(negedge clk);
    start = 1'b0;
    n = wd ? 16 : 8;
    s = 0;
    for (int k = 0; k < 17; k++) begin
      e = n;
      for (int i = n - 1; i > s; i--) if (w[i]) e = i;
      exp = '0;
      for (int l = 4 * s; l < 4 * e; l++) exp[l] = 1'b1;
      exp &= a;
      chk(valid === 1'b1, "R9 valid", 64'(valid), 64'd1);
      chk(lane_en === exp, "R3 layer lanes", lane_en, exp);
      chk(last === (e == n), "R7 last", 64'(last), 64'(e == n));
      chk(empty === (exp == '0), "R6 empty", 64'(empty), 64'(exp == '0));
      if (k == 0 && poke_start) begin
        start = 1'b1; coll_word = ~w; wide = ~wd; act_mask = ~a;
        @(negedge clk);
        start = 1'b0;
        chk(lane_en === exp, "R8 start ignored", lane_en, exp);
      end
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      if (e == n) break;
      s = e;
    end
    chk(valid === 1'b0, "R7 idle after last", 64'(valid), 64'd0);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; step = 1'b0; wide = 1'b0;
    coll_word = '0; act_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(valid === 1'b0 && last === 1'b0 && empty === 1'b0, "R1 flags",
        {61'd0, valid, last, empty}, 64'd0);
    chk(lane_en === '0, "R1 lanes", lane_en, 64'd0);
    // R8: step while idle
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk(valid === 1'b0, "R8 step idle", 64'(valid), 64'd0);
    // R3: worked five-layer example
    run_wave(32'h0000_0384, 1'b1, '1, 1'b0);
    // R4: zero word, both widths (R5 top lane)
    run_wave(32'h0, 1'b1, '1, 1'b0);
    run_wave(32'h0, 1'b0, '1, 1'b0);
    // one quad per layer
    run_wave(32'h0000_FFFF, 1'b1, '1, 1'b0);
    // R10: bit 0 only
    run_wave(32'h1, 1'b0, '1, 1'b0);
    // R2: junk in high bits
    run_wave(32'hFFFF_FF00, 1'b0, '1, 1'b0);
    run_wave(32'hFFFF_0000, 1'b1, '1, 1'b0);
    // R6: empty layers
    run_wave(32'h0000_0110, 1'b1, 64'hF000_0000_0000_000F, 1'b0);
    // R8: start during a sequence
    run_wave(32'h0000_0024, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b1);
    for (int r = 0; r < 40; r++) begin
      run_wave($urandom, 1'($urandom), {$urandom, $urandom}, (r % 7) == 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule